// File: doc/BRIEF.md
# Sized Carry Arithmetic Unit

This unit is a pipelined integer execution slice for 64-bit data paths. It performs add-with-carry and subtract-with-borrow at a chosen operand size of 8, 16, 32 or 64 bits. It also performs an add-upper-immediate operation, which adds a small signed immediate placed at bit 12 to a register value. The carry flag used by the carry operations arrives as an input bit from an emulated flags register. The unit only reads this bit and never writes a flag. Every result narrower than 64 bits is sign-extended to the full data width before it leaves the unit.

The two operation classes have fixed and different latencies, so the unit has two result ports. The add-upper-immediate result appears on a fast port one cycle after issue. Carry and borrow results appear on a slow port two cycles after issue. One operation can be issued in every cycle. Because the latencies differ, results can come back in a different order from the order of issue, and both ports can carry a valid result in the same cycle. The issuing pipeline is responsible for tracking which result belongs to which operation.

Top module: `carry_alu`

## Requirements
- R1: Opcode 0 (add-with-carry) produces, in its low w bits, (a + b + carry_in) mod 2^w. Here w is 8, 16, 32 or 64 for size code 0, 1, 2 or 3.
- R2: Opcode 1 (subtract-with-borrow) produces, in its low w bits, (a − b − carry_in) mod 2^w. Here carry_in acts as the borrow.
- R3: For carry results of size codes 0, 1 and 2, bits 63 down to w are copies of bit w−1. A carry or borrow out of the selected width never changes these bits. For size code 3 the 64-bit sum passes through unchanged.
- R4: Operand bits above the selected width have no effect on a carry or borrow result.
- R5: Opcode 2 (add-upper-immediate) forms its offset by sign-extending the 5-bit immediate and shifting it left by 12.
- R6: Opcode 2 with a size code other than 3 adds the low 32 bits of a and of the offset modulo 2^32, then sign-extends the sum from bit 31.
- R7: Opcode 2 with size code 3 adds the full 64-bit a and the offset modulo 2^64.
- R8: An add-upper-immediate issue raises fast_vld, with its result on fast_data, exactly one clock after issue. fast_vld is low in every other cycle.
- R9: A carry or borrow issue raises slow_vld, with its result on slow_data, exactly two clocks after issue. One issue is accepted per cycle, with no gaps between issues.
- R10: A carry or borrow operation followed one cycle later by an add-upper-immediate operation gives valid results on both ports in the same cycle.
- R11: Opcode 3 is a no-op. It raises neither valid.
- R12: A synchronous active-low reset clears both valids, including for operations already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | An operation is issued this cycle |
| issue_op | input | 2 | 0 add-carry, 1 sub-borrow, 2 add-upper-imm, 3 none |
| issue_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand (carry operations only) |
| imm5 | input | 5 | Signed immediate for add-upper-imm |
| carry_in | input | 1 | Carry or borrow flag bit |
| fast_vld | output | 1 | Add-upper-imm result valid |
| fast_data | output | 64 | Add-upper-imm result |
| slow_vld | output | 1 | Carry/borrow result valid |
| slow_data | output | 64 | Carry/borrow result |

## Verification
The bench drives sums that overflow their width, such as a byte 0xFF + 1 + 1. A design that let the carry leak upward would show a nonzero upper word. The bench also uses results that land exactly on the sign bit, such as 0x7F + carry. A design that zero-extended those results, or extended them from the wrong bit, would lose the sign. Operands carry garbage above the selected width, so a design without truncation returns visibly wrong values. Borrow-only subtractions from zero check that the flag is really subtracted. Negative immediates check that the offset is sign-extended in both the 32-bit and 64-bit forms. On the timing side, the bench checks a carry issue followed by an immediate issue, which a single-port or wrongly delayed design would drop or mislabel. It also checks back-to-back issues, a no-op opcode and a reset that arrives while an operation is in flight.

// File: rtl/acu_pkg.sv
// Shared constants and types of the sized carry arithmetic unit.
// Assumes a data path of XLEN bits, where XLEN is at least 64.
package acu_pkg;
    localparam int XLEN      = 64;
    localparam int IMM_W     = 5;
    localparam int IMM_SHIFT = 12;

    typedef enum logic [1:0] {
        OP_ADC  = 2'd0,
        OP_SBC  = 2'd1,
        OP_AUI  = 2'd2,
        OP_NONE = 2'd3
    } acu_op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acu_size_e;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic            cin;
        logic            sub;
        acu_size_e       size;
    } acu_carry_req_t;
endpackage

// File: rtl/acu_width_mask.sv
// Clears all operand bits above the selected width.
// Purely combinational. Assumes XLEN >= 64.
module acu_width_mask
    import acu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  acu_size_e      size_i,
    input  logic [W-1:0]   data_i,
    output logic [W-1:0]   data_o
);
    // Keep only the low 8/16/32/W bits.
    always_comb begin
        case (size_i)
            SZ_B:    data_o = {{(W-8){1'b0}},  data_i[7:0]};
            SZ_H:    data_o = {{(W-16){1'b0}}, data_i[15:0]};
            SZ_W:    data_o = {{(W-32){1'b0}}, data_i[31:0]};
            default: data_o = data_i;
        endcase
    end
endmodule

// File: rtl/acu_sext.sv
// Sign-extends a sized result from bit 7, 15 or 31 to the full width.
// The double size passes through. Combinational only.
module acu_sext
    import acu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  acu_size_e      size_i,
    input  logic [W-1:0]   data_i,
    output logic [W-1:0]   data_o
);
    // Replicate the sign bit of the selected width.
    always_comb begin
        case (size_i)
            SZ_B:    data_o = {{(W-8){data_i[7]}},   data_i[7:0]};
            SZ_H:    data_o = {{(W-16){data_i[15]}}, data_i[15:0]};
            SZ_W:    data_o = {{(W-32){data_i[31]}}, data_i[31:0]};
            default: data_o = data_i;
        endcase
    end
endmodule

// File: rtl/acu_addsub.sv
// Full-width add with carry or subtract with borrow. The carry out is dropped.
// Bits above the size of interest are don't-care for the caller.
module acu_addsub
    import acu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] cin_ext;
    assign cin_ext = {{(W-1){1'b0}}, cin_i};

    // Select a + b + c or a - b - c, modulo 2^W.
    always_comb begin
        if (sub_i) res_o = a_i - b_i - cin_ext;
        else       res_o = a_i + b_i + cin_ext;
    end
endmodule

// File: rtl/acu_upper_imm.sv
// Adds a sign-extended immediate, shifted left by IMM_SHIFT, to an operand.
// In the narrow form the sum wraps at 32 bits and is sign-extended.
// In the wide form the sum wraps at W bits.
module acu_upper_imm
    import acu_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int IW  = IMM_W,
    parameter int SH  = IMM_SHIFT
) (
    input  logic [W-1:0]  a_i,
    input  logic [IW-1:0] imm_i,
    input  logic          wide_i,
    output logic [W-1:0]  res_o
);
    localparam int NW = 32;

    logic [W-1:0]  offset;
    logic [W-1:0]  sum_wide;
    logic [NW-1:0] sum_narrow;

    // Sign-extend the immediate and move it into position.
    assign offset     = {{(W-IW-SH){imm_i[IW-1]}}, imm_i, {SH{1'b0}}};
    assign sum_wide   = a_i + offset;
    assign sum_narrow = a_i[NW-1:0] + offset[NW-1:0];

    // Pick the 64-bit or the sign-extended 32-bit form.
    always_comb begin
        if (wide_i) res_o = sum_wide;
        else        res_o = {{(W-NW){sum_narrow[NW-1]}}, sum_narrow};
    end
endmodule

// File: rtl/carry_alu.sv
// Top of the sized carry arithmetic unit.
// Add-upper-immediate: one register stage, result on the fast port.
// Add-with-carry / subtract-with-borrow: operands are truncated and registered,
// then computed, sign-extended and registered again, giving the slow port.
// Assumes the issuer accepts both ports every cycle; there is no back-pressure.
module carry_alu
    import acu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_vld,
    input  logic [1:0]    issue_op,
    input  logic [1:0]    issue_size,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [IW-1:0] imm5,
    input  logic          carry_in,
    output logic          fast_vld,
    output logic [W-1:0]  fast_data,
    output logic          slow_vld,
    output logic [W-1:0]  slow_data
);
    localparam int NOPND = 2;

    acu_op_e        op_e;
    acu_size_e      size_e;
    logic           is_aui;
    logic           is_carry;
    logic [W-1:0]   opnd_raw [NOPND];
    logic [W-1:0]   opnd_msk [NOPND];
    logic [W-1:0]   aui_res;
    logic [W-1:0]   raw_sum;
    logic [W-1:0]   ext_sum;

    logic           fast_vld_q;
    logic [W-1:0]   fast_data_q;
    logic           s1_vld_q;
    acu_carry_req_t s1_req_q;
    logic           slow_vld_q;
    logic [W-1:0]   slow_data_q;

    assign op_e     = acu_op_e'(issue_op);
    assign size_e   = acu_size_e'(issue_size);
    assign is_aui   = issue_vld && (op_e == OP_AUI);
    assign is_carry = issue_vld && ((op_e == OP_ADC) || (op_e == OP_SBC));

    assign opnd_raw[0] = src_a;
    assign opnd_raw[1] = src_b;

    // One truncation unit for each source operand.
    for (genvar gi = 0; gi < NOPND; gi++) begin : g_mask
        acu_width_mask #(.W(W)) u_mask (
            .size_i (size_e),
            .data_i (opnd_raw[gi]),
            .data_o (opnd_msk[gi])
        );
    end

    acu_upper_imm #(.W(W), .IW(IW), .SH(IMM_SHIFT)) u_aui (
        .a_i    (src_a),
        .imm_i  (imm5),
        .wide_i (size_e == SZ_D),
        .res_o  (aui_res)
    );

    // Fast path: register the add-upper-immediate result.
    always_ff @(posedge clk) begin
        if (!rst_n) fast_vld_q <= 1'b0;
        else        fast_vld_q <= is_aui;
        if (is_aui) fast_data_q <= aui_res;
    end

    // Slow path stage 1: capture the truncated operands and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_vld_q <= 1'b0;
        else        s1_vld_q <= is_carry;
        if (is_carry) begin
            s1_req_q.a    <= opnd_msk[0];
            s1_req_q.b    <= opnd_msk[1];
            s1_req_q.cin  <= carry_in;
            s1_req_q.sub  <= (op_e == OP_SBC);
            s1_req_q.size <= size_e;
        end
    end

    acu_addsub #(.W(W)) u_addsub (
        .a_i   (s1_req_q.a),
        .b_i   (s1_req_q.b),
        .cin_i (s1_req_q.cin),
        .sub_i (s1_req_q.sub),
        .res_o (raw_sum)
    );

    acu_sext #(.W(W)) u_sext (
        .size_i (s1_req_q.size),
        .data_i (raw_sum),
        .data_o (ext_sum)
    );

    // Slow path stage 2: register the sign-extended carry result.
    always_ff @(posedge clk) begin
        if (!rst_n) slow_vld_q <= 1'b0;
        else        slow_vld_q <= s1_vld_q;
        if (s1_vld_q) slow_data_q <= ext_sum;
    end

    assign fast_vld  = fast_vld_q;
    assign fast_data = fast_data_q;
    assign slow_vld  = slow_vld_q;
    assign slow_data = slow_data_q;
endmodule

// File: rtl/carry_alu_chk.sv
// Timing and sign-extension checker for carry_alu, attached by bind.
// Watches only the ports of the top module.
module carry_alu_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue_vld,
    input logic [1:0]   issue_op,
    input logic [1:0]   issue_size,
    input logic         fast_vld,
    input logic [W-1:0] fast_data,
    input logic         slow_vld,
    input logic [W-1:0] slow_data
);
    AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_op == 2'd2) |=> fast_vld); // R8
    AST_FAST_ONLY_AUI: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_vld && issue_op == 2'd2) |=> !fast_vld); // R8
    AST_SLOW_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && (issue_op == 2'd0 || issue_op == 2'd1)) |=> ##1 slow_vld); // R9
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_op == 2'd3) |=> !fast_vld); // R11
    AST_SEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_vld && $past(issue_size, 2) == 2'd0) |-> (slow_data[W-1:8] == {(W-8){slow_data[7]}})); // R3
    AST_SEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_vld && $past(issue_size, 2) == 2'd2) |-> (slow_data[W-1:32] == {(W-32){slow_data[31]}})); // R3
    AST_AUI_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_vld && $past(issue_size) != 2'd3) |-> (fast_data[W-1:32] == {(W-32){fast_data[31]}})); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!fast_vld && !slow_vld)); // R12
endmodule

bind carry_alu carry_alu_chk #(.W(W)) u_carry_alu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_vld  (issue_vld),
    .issue_op   (issue_op),
    .issue_size (issue_size),
    .fast_vld   (fast_vld),
    .fast_data  (fast_data),
    .slow_vld   (slow_vld),
    .slow_data  (slow_data)
);

// File: tb/test_carry_alu.sv
`timescale 1ns/1ps
// Directed bench for carry_alu: one task per scenario, each checking itself.
module test_carry_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [1:0]  issue_op = 2'd3;
    logic [1:0]  issue_size = 2'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [4:0]  imm5 = '0;
    logic        carry_in = 1'b0;
    logic        fast_vld;
    logic [63:0] fast_data;
    logic        slow_vld;
    logic [63:0] slow_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    carry_alu i_carry_alu (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_op(issue_op),
        .issue_size(issue_size), .src_a(src_a), .src_b(src_b), .imm5(imm5),
        .carry_in(carry_in), .fast_vld(fast_vld), .fast_data(fast_data),
        .slow_vld(slow_vld), .slow_data(slow_data)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Sign-extend from the width given by the size code.
    function automatic logic [63:0] sx(input logic [1:0] sz, input logic [63:0] v);
        case (sz)
            2'd0:    return {{56{v[7]}},  v[7:0]};
            2'd1:    return {{48{v[15]}}, v[15:0]};
            2'd2:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    // Expected carry/borrow result from R1/R2/R3.
    function automatic logic [63:0] ref_carry(input logic sub, input logic [1:0] sz,
                                              input logic [63:0] a, input logic [63:0] b,
                                              input logic c);
        logic [63:0] r;
        r = sub ? (a - b - {63'd0, c}) : (a + b + {63'd0, c});
        return sx(sz, r);
    endfunction

    task automatic drive(input logic [1:0] op, input logic [1:0] sz, input logic [63:0] a,
                         input logic [63:0] b, input logic [4:0] im, input logic c);
        issue_vld = 1'b1; issue_op = op; issue_size = sz;
        src_a = a; src_b = b; imm5 = im; carry_in = c;
    endtask

    task automatic idle();
        issue_vld = 1'b0; issue_op = 2'd3;
        src_a = '1; src_b = '1;
    endtask

    // Single carry/borrow issue, result checked two clocks later.
    task automatic t_carry(input string tag, input logic [1:0] op, input logic [1:0] sz,
                           input logic [63:0] a, input logic [63:0] b, input logic c,
                           input logic [63:0] exp);
        @(negedge clk); drive(op, sz, a, b, 5'd0, c);
        @(negedge clk); idle();
        chk({tag, " early slow_vld"}, {63'd0, slow_vld}, 64'd0);
        @(negedge clk);
        chk({tag, " slow_vld"}, {63'd0, slow_vld}, 64'd1);
        chk({tag, " slow_data"}, slow_data, exp);
    endtask

    // Single add-upper-immediate issue, result checked one clock later.
    task automatic t_aui(input string tag, input logic [1:0] sz, input logic [63:0] a,
                         input logic [4:0] im, input logic [63:0] exp);
        @(negedge clk); drive(2'd2, sz, a, 64'hDEAD, im, 1'b1);
        @(negedge clk); idle();
        chk({tag, " fast_vld"}, {63'd0, fast_vld}, 64'd1);
        chk({tag, " fast_data"}, fast_data, exp);
        @(negedge clk);
        chk({tag, " fast_vld drop"}, {63'd0, fast_vld}, 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset fast_vld", {63'd0, fast_vld}, 64'd0);
        chk("R12 reset slow_vld", {63'd0, slow_vld}, 64'd0);
        rst_n = 1'b1;
    endtask

    // R10: carry issue then immediate issue; both ports valid together.
    task automatic t_overlap();
        @(negedge clk); drive(2'd0, 2'd1, 64'h1111_0000_0000_1234, 64'h0000_0000_0000_0001, 5'd0, 1'b1);
        @(negedge clk); drive(2'd2, 2'd3, 64'h0000_0000_0000_0000, 64'd0, 5'd2, 1'b0);
        @(negedge clk); idle();
        chk("R10 both fast_vld", {63'd0, fast_vld}, 64'd1);
        chk("R10 both slow_vld", {63'd0, slow_vld}, 64'd1);
        chk("R10 fast_data", fast_data, 64'h0000_0000_0000_2000);
        chk("R10 slow_data", slow_data, 64'h0000_0000_0000_1236);
        @(negedge clk);
    endtask

    // R9: four issues with no gap, each result two clocks after issue.
    task automatic t_stream();
        logic [63:0] exp [4];
        logic [63:0] av [4];
        logic [63:0] bv [4];
        av[0] = 64'h0123_4567_89AB_CDEF; bv[0] = 64'hFEDC_BA98_7654_3210;
        av[1] = 64'hFFFF_FFFF_0000_0010; bv[1] = 64'h0000_0000_0000_0020;
        av[2] = 64'h8000_0000_0000_0000; bv[2] = 64'h8000_0000_0000_0000;
        av[3] = 64'h0000_0000_0000_0100; bv[3] = 64'h0000_0000_0000_0001;
        for (int i = 0; i < 4; i++)
            exp[i] = ref_carry(i[0], i[1:0], av[i], bv[i], ~i[0]);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R9 stream slow_vld", {63'd0, slow_vld}, 64'd1);
                chk("R9 stream slow_data", slow_data, exp[i-2]);
            end
            if (i < 4) drive({1'b0, i[0]}, i[1:0], av[i], bv[i], 5'd0, ~i[0]);
            else idle();
        end
    endtask

    // R11: opcode 3 raises no valid.
    task automatic t_nop();
        @(negedge clk); drive(2'd3, 2'd3, 64'h5, 64'h6, 5'd1, 1'b1);
        @(negedge clk); idle();
        chk("R11 nop fast_vld", {63'd0, fast_vld}, 64'd0);
        @(negedge clk);
        chk("R11 nop slow_vld", {63'd0, slow_vld}, 64'd0);
    endtask

    // R12: reset while a carry operation is in flight.
    task automatic t_reset_flight();
        @(negedge clk); drive(2'd0, 2'd3, 64'd1, 64'd1, 5'd0, 1'b0);
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk);
        chk("R12 flush slow_vld", {63'd0, slow_vld}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 flush slow_vld later", {63'd0, slow_vld}, 64'd0);
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        // R1 R3 R4: add-with-carry, carry out of the width discarded
        t_carry("R1 R3 R4 adc byte wrap", 2'd0, 2'd0, 64'hDEAD_BEEF_0000_12FF, 64'hFFFF_0000_0000_0001, 1'b1, 64'h1);
        t_carry("R1 R3 adc byte sign", 2'd0, 2'd0, 64'h7F, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FF80);
        t_carry("R1 R3 R4 adc half", 2'd0, 2'd1, 64'h0000_AAAA_0000_7FFF, 64'h1, 1'b0, 64'hFFFF_FFFF_FFFF_8000);
        t_carry("R1 R4 adc word wrap", 2'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_0000_0000, 1'b1, 64'h0);
        t_carry("R1 R3 adc double", 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'h0);
        // R2: subtract-with-borrow
        t_carry("R2 R3 sbc byte borrow", 2'd1, 2'd0, 64'h0, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        t_carry("R2 R4 sbc half", 2'd1, 2'd1, 64'h0000_0000_1234_0005, 64'h3, 1'b1, 64'h1);
        t_carry("R2 R3 sbc word", 2'd1, 2'd2, 64'h0000_0000_8000_0000, 64'h1, 1'b0, 64'h7FFF_FFFF);
        t_carry("R2 sbc double", 2'd1, 2'd3, 64'h0, 64'h1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        // R5 R6 R7 R8: add-upper-immediate
        t_aui("R5 R6 R8 aui word sign", 2'd2, 64'h1234_5678_7FFF_F000, 5'h01, 64'hFFFF_FFFF_8000_0000);
        t_aui("R5 R6 aui word neg imm", 2'd0, 64'h0000_0000_0000_1000, 5'h1F, 64'h0);
        t_aui("R7 aui double", 2'd3, 64'h0000_0000_7FFF_F000, 5'h01, 64'h0000_0000_8000_0000);
        t_aui("R5 R7 aui double neg", 2'd3, 64'h0, 5'h10, 64'hFFFF_FFFF_FFFF_0000);
        t_aui("R7 aui double carry", 2'd3, 64'h0000_0001_0000_0000, 5'h1F, 64'h0000_0000_FFFF_F000);
        t_overlap();
        t_stream();
        t_nop();
        t_reset_flight();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule